// File: doc/BRIEF.md
# Piecewise-Linear Logistic Activation

This unit turns a signed fixed-point accumulator value into a logistic-style activation between 0 and 1. It does not evaluate an exponential. It approximates the curve with four straight segments on the magnitude of the input. Every slope is a power of two, so the datapath needs only shifts, adds and comparators. A negative input is handled by folding: the result computed for the magnitude is subtracted from 1.

A neural-network datapath places it after its multiply-accumulate array. Each beat that arrives with `act_valid_i` high produces exactly one result with `act_valid_o` high on the next clock. The output register holds its last value between beats. The input is 32 bits with 24 fractional bits. The output is 16 bits with 12 fractional bits, so 1.0 reads as 4096.

Top module: `pwl_sigmoid`

## Requirements
- R1: While `rst_n` is low and on the first edge after it rises, `act_valid_o` is 0 and `act_o` is 0.
- R2: `act_valid_o` is high in exactly the cycle that follows a cycle with `act_valid_i` high, which gives a fixed latency of one cycle.
- R3: When |x| is 5.0 or more, the result is 1.0 (4096) for x ≥ 0 and 0 for x < 0.
- R4: When 2.375 ≤ |x| < 5.0, the magnitude result is |x|/32 + 0.84375, with |x|/32 taken as an arithmetic right shift by 5 at 24 fractional bits.
- R5: When 1.0 ≤ |x| < 2.375, the magnitude result is |x|/8 + 0.625, using a right shift by 3.
- R6: When |x| < 1.0, the magnitude result is |x|/4 + 0.5, using a right shift by 2.
- R7: When x < 0, the result is 1.0 minus the magnitude result. The subtraction happens at 24 fractional bits, before truncation.
- R8: The output is the 24-fractional-bit result with its 12 lowest bits dropped, which truncates it toward zero.
- R9: The most negative input, -2^31, saturates its magnitude instead of overflowing and gives 0.
- R10: While `act_valid_i` is low, `act_o` keeps its previous value whatever `x_i` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| act_valid_i | input | 1 | Input beat strobe |
| x_i | input | 32 | Signed input, 24 fractional bits |
| act_valid_o | output | 1 | Result strobe, one cycle after the input strobe |
| act_o | output | 16 | Activation, 12 fractional bits, range 0 to 4096 |

## Verification
On every cycle, the embedded assertions check:
- the one-cycle strobe relation;
- that the output never exceeds 1.0;
- that a non-negative input gives at least one half and a negative input at most one half;
- saturation at |x| ≥ 5;
- that the output holds while no beat arrives.

They cannot see the exact segment values, the truncation or the most-negative corner. The bench shows these by comparing every result with an arithmetic model. It sweeps a dense grid from -6 to +6 and hits each breakpoint and the value just below it.

// File: rtl/pwl_sigmoid.sv
module pwl_sigmoid #(
  parameter int IW = 32,
  parameter int IF = 24,
  parameter int OW = 16,
  parameter int OF = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 act_valid_i,
  input  logic signed [IW-1:0] x_i,
  output logic                 act_valid_o,
  output logic [OW-1:0]        act_o
);

  localparam int YW = IF + 2;
  localparam int DROP = IF - OF;
  localparam logic [IW-1:0] MAG_MAX = {1'b0, {(IW-1){1'b1}}};
  localparam logic [IW-1:0] MOST_NEG = {1'b1, {(IW-1){1'b0}}};
  localparam logic [IW-1:0] BRK_SAT = IW'(5) << IF;
  localparam logic [IW-1:0] BRK_HI = IW'(19) << (IF - 3);
  localparam logic [IW-1:0] BRK_MID = IW'(1) << IF;
  localparam logic [YW-1:0] Y_ONE = YW'(1) << IF;
  localparam logic [YW-1:0] OFS_HI = YW'(27) << (IF - 5);
  localparam logic [YW-1:0] OFS_MID = YW'(5) << (IF - 3);
  localparam logic [YW-1:0] OFS_LO = YW'(1) << (IF - 1);
  localparam logic [OW-1:0] OUT_ONE = OW'(1) << OF;
  localparam logic [OW-1:0] OUT_HALF = OW'(1) << (OF - 1);

  logic          neg;
  logic [IW-1:0] mag;
  logic [YW-1:0] y_mag;
  logic [YW-1:0] y_fold;
  logic [YW-1:0] y_trunc;

  assign neg = x_i[IW-1];
  assign mag = !neg ? x_i : (x_i == MOST_NEG) ? MAG_MAX : -x_i;

  always_comb begin
    if (mag >= BRK_SAT)
      y_mag = Y_ONE;
    else if (mag >= BRK_HI)
      y_mag = YW'(mag >> 5) + OFS_HI;
    else if (mag >= BRK_MID)
      y_mag = YW'(mag >> 3) + OFS_MID;
    else
      y_mag = YW'(mag >> 2) + OFS_LO;
  end

  assign y_fold  = neg ? (Y_ONE - y_mag) : y_mag;
  assign y_trunc = y_fold >> DROP;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_valid_o <= 1'b0;
      act_o       <= '0;
    end else begin
      act_valid_o <= act_valid_i;
      if (act_valid_i)
        act_o <= OW'(y_trunc);
    end
  end

  initial begin
    AST_PARAM_FIT: assert (IF >= 5 && IF >= OF && OF >= 1 && IW - IF >= 4 && OW >= OF + 1); // R8
  end

  AST_LATENCY_HI: assert property (@(posedge clk) disable iff (!rst_n)
    act_valid_i |=> act_valid_o); // R2
  AST_LATENCY_LO: assert property (@(posedge clk) disable iff (!rst_n)
    !act_valid_i |=> !act_valid_o); // R2
  AST_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    act_o <= OUT_ONE); // R3
  AST_SAT_POS: assert property (@(posedge clk) disable iff (!rst_n)
    (act_valid_i && x_i >= $signed(BRK_SAT)) |=> act_o == OUT_ONE); // R3
  AST_SAT_NEG: assert property (@(posedge clk) disable iff (!rst_n)
    (act_valid_i && x_i <= -$signed(BRK_SAT)) |=> act_o == '0); // R3
  AST_POS_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    (act_valid_i && !x_i[IW-1]) |=> act_o >= OUT_HALF); // R6
  AST_NEG_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    (act_valid_i && x_i[IW-1]) |=> act_o <= OUT_HALF); // R7
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !act_valid_i |=> $stable(act_o)); // R10

endmodule

// File: tb/sim_pwl_sigmoid.sv
module sim_pwl_sigmoid;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic act_valid_i = 1'b0;
  logic signed [31:0] x_i = '0;
  logic act_valid_o;
  logic [15:0] act_o;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pwl_sigmoid u0 (.clk(clk), .rst_n(rst_n), .act_valid_i(act_valid_i), .x_i(x_i),
                  .act_valid_o(act_valid_o), .act_o(act_o));

  localparam longint ONE24 = 64'd1 << 24;

  function automatic longint model(longint x);
    longint m;
    longint y;
    m = (x < 0) ? -x : x;
    if (m > 64'h7FFF_FFFF) m = 64'h7FFF_FFFF;
    if (m >= 5 * ONE24)              y = ONE24;
    else if (m * 8 >= 19 * ONE24)    y = m / 32 + (27 * ONE24) / 32;
    else if (m >= ONE24)             y = m / 8 + (5 * ONE24) / 8;
    else                             y = m / 4 + ONE24 / 2;
    if (x < 0) y = ONE24 - y;
    return y / 4096;
  endfunction

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic beat(string req, longint x);
    @(negedge clk);
    x_i = 32'(x);
    act_valid_i = 1'b1;
    @(posedge clk);
    #2;
    check({req, " value"}, act_o, model(x));
    check("R2 valid", act_valid_o, 1);
  endtask

  initial begin
    #4000000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check("R1 valid in reset", act_valid_o, 0);
    check("R1 out in reset", act_o, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #2;
    check("R1 valid after reset", act_valid_o, 0);
    check("R1 out after reset", act_o, 0);

    // dense sweep of -6..+6 with an odd low-bit pattern (R3..R8)
    for (int i = -3072; i <= 3072; i++) begin
      longint x = longint'(i) * (ONE24 / 512) + ((i * 7919) & 32'h7FFF);
      beat((x >= 5 * ONE24 || x <= -5 * ONE24) ? "R3" :
           (x < 0) ? "R7" : "R8", x);
    end

    // breakpoints, and the value just below each, on both signs (R3 R4 R5 R6)
    beat("R6", 0);
    beat("R6", ONE24 - 1);
    beat("R5", ONE24);
    beat("R5", (19 * ONE24) / 8 - 1);
    beat("R4", (19 * ONE24) / 8);
    beat("R4", 5 * ONE24 - 1);
    beat("R3", 5 * ONE24);
    beat("R7", -1);
    beat("R7", -(ONE24 - 1));
    beat("R7", -ONE24);
    beat("R7", -((19 * ONE24) / 8));
    beat("R7", -(5 * ONE24 - 1));
    beat("R3", -5 * ONE24);
    beat("R3", 64'h7FFF_FFFF);
    beat("R9", -64'sd2147483648);
    check("R9 most negative", act_o, 0);

    // hold while no beat arrives (R10, R2)
    beat("R8", 3 * ONE24 / 2 + 4095);
    @(negedge clk);
    act_valid_i = 1'b0;
    x_i = 32'sh8000_0000;
    @(posedge clk);
    #2;
    check("R2 no beat", act_valid_o, 0);
    check("R10 hold", act_o, model(3 * ONE24 / 2 + 4095));
    @(negedge clk);
    x_i = 32'(7 * ONE24);
    @(posedge clk);
    #2;
    check("R10 hold again", act_o, model(3 * ONE24 / 2 + 4095));
    check("R2 still idle", act_valid_o, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule